// File: doc/BRIEF.md
# Segmented ROM/RAM Cartridge Bank Mapper

This block maps banks into the 4 KB cartridge window (0x1000 to 0x1FFF) of an 8-bit CPU bus that carries a 13-bit address. The window is split into four 1 KB slots. A write to one of two control addresses in the low page selects a bank for a slot. A ROM bank is 1 KB and fills its whole slot. A RAM bank is 512 bytes and shows up twice: a read port and a write port 0x800 higher. The map is held as eight 512-byte region entries, so ROM and RAM halves can be mixed freely across the window.

Reads resolve in the same cycle as the address. The block returns a ROM byte, a RAM byte, the current bus byte (on a write-port read, which also stores that byte into RAM), or a pseudo-random byte for a region that has nothing mapped. The ROM image is a fixed function of the image address, so the model needs no stored table. The RAM is a behavioural array inside the block.

Top module: `cart_bank_mapper`

## Requirements
- R1: After reset, regions 0x1000-0x13FF and 0x1C00-0x1FFF both read ROM bank 0. Its first half sits at the slot base and its second half 0x200 higher. All other regions are undefined.
- R2: A write to exactly 0x003E selects a RAM bank, and a write to exactly 0x003F selects a ROM bank. The written byte carries the target slot in bits 7:6 and the bank number in bits 5:0. Writes to any other low-page address (for example 0x003D, or 0x007F) change no mapping.
- R3: Selecting ROM bank b for slot s maps image address b*1024+h*512+o at window address 0x1000+s*0x400+h*0x200+o. Each ROM byte equals A[7:0] XOR low8(A[15:8]*0x1D), where A is the 16-bit image address.
- R4: A ROM bank number of ROM_BANKS or above is reduced modulo ROM_BANKS. With the default of 6, bank 7 acts as bank 1 and bank 6 acts as bank 0.
- R5: Selecting RAM bank b for slot s places its read port at 0x1000+s*0x200 and its write port at 0x1800+s*0x200. Offset o in either port addresses RAM byte b*512+o. The bank number is reduced modulo RAM_BANKS (default 8). No other region changes.
- R6: A write into a ROM region, a RAM read-port region or an undefined region changes no stored data.
- R7: A read of a RAM write-port region returns the current bus data byte (cpu_data). That byte is also stored into the addressed RAM byte.
- R8: A read of an undefined region returns the state of an 8-bit LFSR. The LFSR resets to 0xA5 and, after each such read, steps to {s[6:0], s[7]^s[5]^s[4]^s[3]}.
- R9: While lock is high, a control write changes no mapping.
- R10: rd_data reflects the address in the same cycle. A bank select or RAM write is visible to the read in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lock | input | 1 | Blocks all bank selection while high |
| cpu_addr | input | 13 | CPU address |
| cpu_we | input | 1 | Bus write strobe |
| cpu_re | input | 1 | Bus read strobe |
| cpu_data | input | 8 | Bus data byte (write data, or bus state during a read) |
| rd_data | output | 8 | Read data for the window, 0 outside it |

## Verification
Two things can land in the same cycle: a control write, and a raised lock that must cancel it. The bench drives a ROM select for slot 3 with lock high in that very cycle, then reads the slot and expects ROM bank 0 still there. It then repeats the select with lock low and expects the new bank on the next cycle. A second overlap is the write-port read, where one read cycle both returns the bus byte and stores it. This is judged by reading the same RAM byte through the read port on the following cycle.

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper #(
  parameter int ROM_BANKS = 6,
  parameter int RAM_BANKS = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        lock,
  input  logic [12:0] cpu_addr,
  input  logic        cpu_we,
  input  logic        cpu_re,
  input  logic [7:0]  cpu_data,
  output logic [7:0]  rd_data
);
  localparam int RAM_BYTES = RAM_BANKS * 512;
  localparam int RAM_AW    = $clog2(RAM_BYTES);
  localparam logic [7:0][8:0] RESET_MAP =
    {9'h140, 9'h100, 9'h000, 9'h000, 9'h000, 9'h000, 9'h140, 9'h100};

  logic [7:0][8:0] map;
  logic [7:0]      ram [RAM_BYTES];
  logic [7:0]      lfsr;

  wire        in_win   = cpu_addr[12];
  wire [8:0]  ent      = map[cpu_addr[11:9]];
  wire [8:0]  off      = cpu_addr[8:0];
  wire        is_rom   = ent[8] & ~ent[7];
  wire        is_rdp   = ent[8] & ent[7] & ~ent[6];
  wire        is_wrp   = ent[8] & ent[7] & ent[6];
  wire        hot_wr   = cpu_we & ~lock & (cpu_addr[12:1] == 12'h01F);
  wire [1:0]  slot     = cpu_data[7:6];
  wire [5:0]  rom_bank = 6'(32'(cpu_data[5:0]) % ROM_BANKS);
  wire [5:0]  ram_bank = 6'(32'(cpu_data[5:0]) % RAM_BANKS);
  wire [RAM_AW-1:0] ram_idx = RAM_AW'({ent[5:0], off});
  wire [15:0] rom_addr = {ent[5:0], ent[6], off};
  wire        ram_wr   = in_win & is_wrp & (cpu_we | cpu_re);
  wire        undef_rd = in_win & cpu_re & ~cpu_we & ~ent[8];

  function automatic logic [7:0] rom_byte(input logic [15:0] a);
    logic [7:0] m;
    m = 8'(a[15:8] * 8'h1D);
    return a[7:0] ^ m;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      map <= RESET_MAP;
    end else if (hot_wr) begin
      if (!cpu_addr[0]) begin
        map[{1'b0, slot}] <= {3'b110, ram_bank};
        map[{1'b1, slot}] <= {3'b111, ram_bank};
      end else begin
        map[{slot, 1'b0}] <= {3'b100, rom_bank};
        map[{slot, 1'b1}] <= {3'b101, rom_bank};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      lfsr <= 8'hA5;
    else if (undef_rd)
      lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
  end

  always_ff @(posedge clk) begin
    if (ram_wr)
      ram[ram_idx] <= cpu_data;
  end

  always_comb begin
    if (!in_win)     rd_data = 8'h00;
    else if (is_rom) rd_data = rom_byte(rom_addr);
    else if (is_rdp) rd_data = ram[ram_idx];
    else if (is_wrp) rd_data = cpu_data;
    else             rd_data = lfsr;
  end

  a_r3_rom_halves: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_we && !lock && cpu_addr == 13'h003F) |=>
      (map[{$past(cpu_data[7:6]), 1'b0}][8:6] == 3'b100 &&
       map[{$past(cpu_data[7:6]), 1'b1}][8:6] == 3'b101 &&
       map[{$past(cpu_data[7:6]), 1'b0}][5:0] == map[{$past(cpu_data[7:6]), 1'b1}][5:0]));

  a_r5_ram_ports: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_we && !lock && cpu_addr == 13'h003E) |=>
      (map[{1'b0, $past(cpu_data[7:6])}][8:6] == 3'b110 &&
       map[{1'b1, $past(cpu_data[7:6])}][8:6] == 3'b111 &&
       map[{1'b0, $past(cpu_data[7:6])}][5:0] == map[{1'b1, $past(cpu_data[7:6])}][5:0]));

  a_r9_lock_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> $stable(map));

  a_r7_spurious_store: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_re && !cpu_we && in_win && is_wrp) |=> (ram[$past(ram_idx)] == $past(cpu_data)));

  a_r8_lfsr_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr != 8'h00);

  a_r2_other_low_writes: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_we && !cpu_addr[12] && cpu_addr[12:1] != 12'h01F) |=> $stable(map));
endmodule

// File: tb/cart_bank_mapper_tb.sv
`timescale 1ns/1ps
module cart_bank_mapper_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lock = 1'b0;
  logic [12:0] cpu_addr = '0;
  logic        cpu_we = 1'b0;
  logic        cpu_re = 1'b0;
  logic [7:0]  cpu_data = '0;
  logic [7:0]  rd_data;

  int  n_vec = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;
  logic [7:0] lfsr_m = 8'hA5;

  always #2.5 clk = ~clk;

  cart_bank_mapper u_dut (
    .clk(clk), .rst_n(rst_n), .lock(lock), .cpu_addr(cpu_addr),
    .cpu_we(cpu_we), .cpu_re(cpu_re), .cpu_data(cpu_data), .rd_data(rd_data)
  );

  // op nibble | addr (16b) | data byte | expected (16b)
  // op 0: write; op 1: read, expect ROM byte of image address; op 2: read with bus byte, expect byte
  localparam int NV = 31;
  localparam logic [43:0] VEC [NV] = '{
    44'h0_003F_42_0000, // R2 R3 slot1 <- ROM bank 2
    44'h1_1400_00_0800, // R3 R10
    44'h1_1655_00_0A55, // R3 upper half
    44'h0_003F_87_0000, // R4 slot2 <- bank 7 -> 1
    44'h1_1800_00_0400, // R4
    44'h1_1BFF_00_07FF, // R4
    44'h0_003D_C4_0000, // R2 not a control address
    44'h0_007F_C4_0000, // R2 no mirror
    44'h0_103F_C4_0000, // R6 write into ROM region
    44'h1_1C00_00_0000, // R2 slot3 unchanged
    44'h1_103F_00_003F, // R6 ROM byte intact
    44'h0_003E_43_0000, // R5 slot1 <- RAM bank 3
    44'h0_1A10_5C_0000, // R5 write port
    44'h2_1210_00_005C, // R5 R10 read port
    44'h1_1000_00_0000, // R5 region 0 untouched
    44'h1_1410_00_0810, // R5 region 2 untouched
    44'h2_1A20_77_0077, // R7 write-port read returns bus
    44'h2_1220_00_0077, // R7 stored
    44'h0_1210_99_0000, // R6 write into read port
    44'h2_1210_00_005C, // R6
    44'h0_003E_0B_0000, // R5 slot0 <- RAM bank 11 -> 3
    44'h2_1010_00_005C, // R5 wrap
    44'h2_1220_00_0077, // R5
    44'h0_1830_E1_0000, // R5 write port at 0x1800
    44'h2_1030_00_00E1, // R5
    44'h2_1230_00_00E1, // R5 same bank through region 1
    44'h0_003F_86_0000, // R4 slot2 <- bank 6 -> 0
    44'h1_1844_00_0044, // R4
    44'h1_1A44_00_0244, // R4
    44'h0_003F_45_0000, // R4 slot1 <- bank 5 (largest)
    44'h1_1601_00_1601  // R4
  };

  function automatic logic [7:0] rom_m(input logic [15:0] a);
    logic [7:0] m;
    m = 8'(a[15:8] * 8'h1D);
    return a[7:0] ^ m;
  endfunction

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: rd_data=%h expected=%h at t=%0t", req, got, exp, $time);
    end
  endtask

  task automatic wr(input logic [12:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_data = d; cpu_we = 1'b1; cpu_re = 1'b0;
    @(negedge clk);
    cpu_we = 1'b0;
  endtask

  task automatic rd(input string req, input logic [12:0] a, input logic [7:0] bus, input logic [7:0] exp);
    @(negedge clk);
    cpu_addr = a; cpu_data = bus; cpu_re = 1'b1; cpu_we = 1'b0;
    #1;
    check(req, rd_data, exp);
    @(negedge clk);
    cpu_re = 1'b0;
  endtask

  task automatic rd_undef(input string req, input logic [12:0] a);
    rd(req, a, 8'h00, lfsr_m);
    lfsr_m = {lfsr_m[6:0], lfsr_m[7] ^ lfsr_m[5] ^ lfsr_m[4] ^ lfsr_m[3]};
  endtask

  initial begin
    #20000;
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1 reset map
    rd("R1", 13'h1000, 8'h00, rom_m(16'h0000));
    rd("R1", 13'h1200, 8'h00, rom_m(16'h0200));
    rd("R1", 13'h1C05, 8'h00, rom_m(16'h0005));
    rd("R1", 13'h1E05, 8'h00, rom_m(16'h0205));
    // R8 undefined regions yield LFSR sequence
    rd_undef("R8", 13'h1400);
    rd_undef("R8", 13'h1600);
    wr(13'h1910, 8'h3C);              // R6 write into undefined region
    rd_undef("R8", 13'h1910);
    rd_undef("R8", 13'h1BFF);

    for (int i = 0; i < NV; i++) begin
      logic [3:0]  op;
      logic [12:0] a;
      logic [7:0]  d;
      logic [15:0] e;
      op = VEC[i][43:40]; a = VEC[i][36:24]; d = VEC[i][23:16]; e = VEC[i][15:0];
      case (op)
        4'd0: wr(a, d);
        4'd1: rd($sformatf("vec%0d", i), a, 8'h00, rom_m(e));
        default: rd($sformatf("vec%0d", i), a, d, e[7:0]);
      endcase
    end

    // R9 lock raised in the same cycle as a control write
    @(negedge clk);
    lock = 1'b1; cpu_addr = 13'h003F; cpu_data = 8'hC2; cpu_we = 1'b1;
    @(negedge clk);
    cpu_we = 1'b0; lock = 1'b0;
    rd("R9", 13'h1C00, 8'h00, rom_m(16'h0000));
    @(negedge clk);
    lock = 1'b1; cpu_addr = 13'h003E; cpu_data = 8'hC5; cpu_we = 1'b1;
    @(negedge clk);
    cpu_we = 1'b0; lock = 1'b0;
    rd("R9", 13'h1E10, 8'h00, rom_m(16'h0210));
    // R10 same select without lock shows next cycle
    wr(13'h003F, 8'hC2);
    rd("R10", 13'h1C00, 8'h00, rom_m(16'h0800));
    rd("R3", 13'h1FFF, 8'h00, rom_m(16'h0BFF));

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule